// File: doc/BRIEF.md
# Word Clock Synchronization Monitor

This block sits beside the receive side of a serial audio port that runs as a clock slave. A frame counter advances on every bit-clock rising edge seen in the system-clock domain. The block compares each incoming word-clock rising edge with the place where that counter expects a new frame to start. Small drift is tolerated and the counter is left as it is. Drift beyond a limit that depends on the frame size mutes the data path. While the path is muted, the block realigns the counter to the next word-clock edge and then waits for one clean frame before it releases the mute.

The bit clock and the word clock may arrive with any phase relative to the system clock. They only have to stay synchronous with it and run slower than half the system-clock rate. Both are brought in through synchronizer flops. A frame starts on the bit-clock rising edge at which the sampled word clock goes from low to high. A frame counter value of 0 marks that bit.

Top module: `wclk_sync_monitor`

## Requirements
- R1: While reset is held, and right after reset is released, `muted` is 1 and `resync_pulse` is 0. The block stays muted until it has acquired the word clock as described in R2 and R3.
- R2: After reset, the first word-clock rising edge aligns the frame counter to bit 0 and produces exactly one `resync_pulse`. `muted` stays 1 after this edge.
- R3: After an alignment, the next word-clock rising edge releases the mute (`muted` goes to 0) if its deviation is within the allowed limit. The mute is never released at the aligning edge itself.
- R4: With `frame48` = 0 (64 bit clocks per frame), the block does nothing when a word-clock edge lands up to 6 bit clocks early or late. This covers both the quiet band (up to 4) and the band of 5 and 6: `muted` stays 0 and no pulse is produced.
- R5: With `frame48` = 0, a word-clock edge that is 7 or more bit clocks late or early sets `muted` to 1 within the same sample period. That edge produces no pulse.
- R6: With `frame48` = 1 (48 bit clocks per frame), a deviation of up to 5 bit clocks causes no action. A deviation of 6 or more mutes the output.
- R7: A tolerated deviation does not move the frame counter, so offsets add up. After a +6 shift in a 64-clock frame, a further +1 shift mutes the output.
- R8: After a loss, the next word-clock rising edge realigns the counter and produces one `resync_pulse` while `muted` stays 1. The edge that follows one clean frame releases the mute.
- R9: If the first edge after a realignment deviates beyond the limit, the block realigns again at that edge, produces another pulse and stays muted.
- R10: `resync_pulse` is high for exactly one system-clock cycle each time, and only while `muted` is 1.
- R11: The behaviour above does not depend on the ratio of system-clock to bit-clock period, provided each bit-clock phase lasts at least three system-clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bck_in | input | 1 | Received bit clock (asynchronous phase) |
| lrck_in | input | 1 | Received word clock; a rising edge starts a frame |
| frame48 | input | 1 | 1 selects 48 bit clocks per frame, 0 selects 64 |
| muted | output | 1 | 1 forces the data path to zero |
| resync_pulse | output | 1 | One-cycle pulse each time the counter is realigned |

## Verification
The bench shifts frames by exactly the band edges: ±6 and ±7 for 64-clock frames, and 5 and 6 for 48-clock frames. A threshold that is off by one either mutes on a tolerated shift or misses a real loss. A design that quietly corrects tolerated drift is caught by stacking a +6 shift and a +1 shift, which must mute only if nothing was corrected. Other errors are caught when they appear in the pulse count or the mute flag. These include releasing the mute at the aligning edge, skipping the realignment when the verification frame is bad, and stretching the pulse over more than one cycle. All runs are repeated with a different bit-clock-to-system-clock ratio.

// File: rtl/wcsm_pkg.sv
package wcsm_pkg;

  typedef enum logic [1:0] {
    ST_ACQUIRE = 2'd0,
    ST_VERIFY  = 2'd1,
    ST_LOCKED  = 2'd2
  } lock_state_t;

endpackage

// File: rtl/wcsm_sync.sv
module wcsm_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '0;
    else     pipe[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[i] <= '0;
      else     pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/wcsm_bit_sampler.sv
module wcsm_bit_sampler (
  input  logic clk,
  input  logic rst,
  input  logic bck_s,
  input  logic lrck_s,
  output logic bit_stb,
  output logic frame_stb
);

  logic bck_q;
  logic lrck_at_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      bck_q       <= 1'b0;
      lrck_at_bit <= 1'b0;
    end else begin
      bck_q <= bck_s;
      if (bit_stb) lrck_at_bit <= lrck_s;
    end
  end

  assign bit_stb   = bck_s & ~bck_q;
  assign frame_stb = bit_stb & lrck_s & ~lrck_at_bit;

endmodule

// File: rtl/wcsm_frame_ctr.sv
module wcsm_frame_ctr #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_stb,
  input  logic             align,
  input  logic [CNT_W-1:0] frame_len,
  input  logic [CNT_W-1:0] loss_limit,
  output logic [CNT_W-1:0] bitpos,
  output logic             lost
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] nxt;
  logic [CNT_W-1:0] half_len;
  logic [CNT_W-1:0] dev_mag;

  assign half_len = frame_len >> 1;
  assign nxt      = (cnt >= frame_len - CNT_W'(1)) ? '0 : cnt + CNT_W'(1);
  assign dev_mag  = (nxt < half_len) ? nxt : frame_len - nxt;
  assign lost     = dev_mag > loss_limit;

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (bit_stb) cnt <= align ? '0 : nxt;
  end

  assign bitpos = cnt;

endmodule

// File: rtl/wcsm_lock_fsm.sv
module wcsm_lock_fsm
  import wcsm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic frame_stb,
  input  logic lost,
  output logic align,
  output logic muted,
  output logic resync_pulse
);

  lock_state_t st;

  always_comb begin
    align = 1'b0;
    if (frame_stb) begin
      if (st == ST_ACQUIRE)             align = 1'b1;
      else if (st == ST_VERIFY && lost) align = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_ACQUIRE;
      muted        <= 1'b1;
      resync_pulse <= 1'b0;
    end else begin
      resync_pulse <= align;
      if (frame_stb) begin
        case (st)
          ST_ACQUIRE: st <= ST_VERIFY;
          ST_VERIFY: begin
            if (!lost) begin
              st    <= ST_LOCKED;
              muted <= 1'b0;
            end
          end
          ST_LOCKED: begin
            if (lost) begin
              st    <= ST_ACQUIRE;
              muted <= 1'b1;
            end
          end
          default: begin
            st    <= ST_ACQUIRE;
            muted <= 1'b1;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/wclk_sync_monitor.sv
module wclk_sync_monitor #(
  parameter int SYNC_STAGES = 2,
  parameter int LEN_LONG    = 64,
  parameter int LEN_SHORT   = 48,
  parameter int LOSS_LONG   = 6,
  parameter int LOSS_SHORT  = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic bck_in,
  input  logic lrck_in,
  input  logic frame48,
  output logic muted,
  output logic resync_pulse
);

  localparam int CNT_W = $clog2(LEN_LONG + 1);

  logic [1:0]       sync_q;
  logic             bit_stb;
  logic             frame_stb;
  logic             align;
  logic             lost;
  logic [CNT_W-1:0] frame_len;
  logic [CNT_W-1:0] loss_limit;
  logic [CNT_W-1:0] bitpos;

  assign frame_len  = frame48 ? CNT_W'(LEN_SHORT)  : CNT_W'(LEN_LONG);
  assign loss_limit = frame48 ? CNT_W'(LOSS_SHORT) : CNT_W'(LOSS_LONG);

  wcsm_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({lrck_in, bck_in}),
    .q   (sync_q)
  );

  wcsm_bit_sampler u_sampler (
    .clk       (clk),
    .rst       (rst),
    .bck_s     (sync_q[0]),
    .lrck_s    (sync_q[1]),
    .bit_stb   (bit_stb),
    .frame_stb (frame_stb)
  );

  wcsm_frame_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .bit_stb    (bit_stb),
    .align      (align),
    .frame_len  (frame_len),
    .loss_limit (loss_limit),
    .bitpos     (bitpos),
    .lost       (lost)
  );

  wcsm_lock_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .frame_stb    (frame_stb),
    .lost         (lost),
    .align        (align),
    .muted        (muted),
    .resync_pulse (resync_pulse)
  );

endmodule

// File: rtl/wcsm_checker.sv
module wcsm_checker #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             muted,
  input logic             resync_pulse,
  input logic             frame_stb,
  input logic [CNT_W-1:0] bitpos,
  input logic [CNT_W-1:0] frame_len
);

  logic rst_seen = 1'b0;

  always_ff @(posedge clk) begin
    rst_seen <= rst;
    if (rst_seen) begin
      assert_reset_mutes_R1: assert (muted && !resync_pulse)
        else $error("muted/pulse wrong after reset");
    end
  end

  assert_pulse_single_R10: assert property (@(posedge clk) disable iff (rst)
    resync_pulse |=> !resync_pulse);

  assert_pulse_while_muted_R10: assert property (@(posedge clk) disable iff (rst)
    resync_pulse |-> muted);

  assert_release_on_edge_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(muted) |-> $past(frame_stb));

  assert_mute_on_edge_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(muted) |-> $past(frame_stb));

  assert_bitpos_range_R7: assert property (@(posedge clk) disable iff (rst)
    bitpos < frame_len);

endmodule

bind wclk_sync_monitor wcsm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .muted        (muted),
  .resync_pulse (resync_pulse),
  .frame_stb    (frame_stb),
  .bitpos       (bitpos),
  .frame_len    (frame_len)
);

// File: tb/sim_wclk_sync_monitor.sv
`timescale 1ns/1ps
module sim_wclk_sync_monitor;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bck = 1'b0;
  logic lrck = 1'b0;
  logic frame48 = 1'b0;
  logic muted;
  logic resync_pulse;

  int checks = 0;
  int fails = 0;
  int pulses = 0;
  int long_pulses = 0;
  int half = 4;
  int cyc = 0;
  logic pulse_prev = 1'b0;

  always #2 clk = ~clk;

  wclk_sync_monitor u0 (
    .clk          (clk),
    .rst          (rst),
    .bck_in       (bck),
    .lrck_in      (lrck),
    .frame48      (frame48),
    .muted        (muted),
    .resync_pulse (resync_pulse)
  );

  always @(negedge clk) begin
    if (resync_pulse) pulses++;
    if (resync_pulse && pulse_prev) long_pulses++;
    pulse_prev <= resync_pulse;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_bits(input int n, input logic lv);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lrck = lv;
      bck  = 1'b0;
      repeat (half) @(negedge clk);
      bck = 1'b1;
      repeat (half - 1) @(negedge clk);
    end
  endtask

  task automatic frame(input int len);
    send_bits(len / 2, 1'b1);
    send_bits(len - len / 2, 1'b0);
  endtask

  task automatic do_reset(input logic sel48);
    @(negedge clk);
    rst = 1'b1;
    frame48 = sel48;
    lrck = 1'b0;
    bck = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset(input logic sel48);
    int p0;
    do_reset(sel48);
    p0 = pulses;
    repeat (3) @(negedge clk);
    check(muted == 1'b1, "R1 muted after reset", int'(muted), 1);
    check(pulses == p0, "R1 no pulse after reset", pulses - p0, 0);
  endtask

  task automatic t_acquire(input int n);
    int p0;
    p0 = pulses;
    frame(n);
    check(pulses == p0 + 1, "R2 one pulse at first edge", pulses - p0, 1);
    check(muted == 1'b1, "R3 still muted at aligning edge", int'(muted), 1);
    frame(n);
    check(muted == 1'b0, "R3 released after clean frame", int'(muted), 0);
    check(pulses == p0 + 1, "R3 no extra pulse on release", pulses - p0, 1);
  endtask

  task automatic t_tolerate(input int n, input int k, input string req);
    int p0;
    p0 = pulses;
    frame(n + k);
    frame(n);
    check(muted == 1'b0, req, int'(muted), 0);
    frame(n - k);
    frame(n);
    check(muted == 1'b0, req, int'(muted), 0);
    check(pulses == p0, req, pulses - p0, 0);
  endtask

  task automatic t_relock(input int n, input string req);
    int p0;
    p0 = pulses;
    frame(n);
    check(pulses == p0 + 1, req, pulses - p0, 1);
    check(muted == 1'b1, req, int'(muted), 1);
    frame(n);
    check(muted == 1'b0, req, int'(muted), 0);
  endtask

  task automatic t_loss(input int n, input int shift, input string req);
    int p0;
    p0 = pulses;
    frame(n + shift);
    frame(n);
    check(muted == 1'b1, req, int'(muted), 1);
    check(pulses == p0, req, pulses - p0, 0);
    t_relock(n, "R8 realign then release");
  endtask

  task automatic t_not_adjusted(input int n);
    frame(n + 6);
    frame(n);
    check(muted == 1'b0, "R7 +6 tolerated", int'(muted), 0);
    frame(n + 1);
    frame(n);
    check(muted == 1'b1, "R7 offsets accumulate to 7", int'(muted), 1);
    t_relock(n, "R8 relock after accumulated loss");
  endtask

  task automatic t_verify_fail(input int n);
    int p0;
    p0 = pulses;
    frame(n + 7);
    frame(n);
    check(muted == 1'b1, "R5 loss before verify test", int'(muted), 1);
    frame(n + 7);
    check(pulses == p0 + 1, "R8 realign pulse", pulses - p0, 1);
    frame(n);
    check(pulses == p0 + 2, "R9 second realign on bad verify", pulses - p0, 2);
    check(muted == 1'b1, "R9 stays muted on bad verify", int'(muted), 1);
    frame(n);
    check(muted == 1'b0, "R9 release after clean frame", int'(muted), 0);
  endtask

  task automatic t_reset_mid(input int n);
    int p0;
    check(muted == 1'b0, "R1 locked before mid reset", int'(muted), 0);
    p0 = pulses;
    do_reset(frame48);
    check(muted == 1'b1, "R1 mid-run reset mutes", int'(muted), 1);
    check(pulses == p0, "R1 no pulse from reset", pulses - p0, 0);
    t_acquire(n);
  endtask

  initial begin
    t_reset(1'b0);
    t_acquire(64);
    t_tolerate(64, 4, "R4 quiet band 4");
    t_tolerate(64, 6, "R4 band of 6 ignored");
    t_loss(64, 7, "R5 late by 7");
    t_loss(64, -7, "R5 early by 7");
    t_not_adjusted(64);
    t_verify_fail(64);
    t_reset_mid(64);

    t_reset(1'b1);
    t_acquire(48);
    t_tolerate(48, 3, "R6 quiet band 3");
    t_tolerate(48, 5, "R6 band of 5 ignored");
    t_loss(48, 6, "R6 late by 6");
    t_loss(48, -6, "R6 early by 6");

    half = 3;
    t_reset(1'b0);
    t_acquire(64);
    t_tolerate(64, 6, "R11 ratio change tolerance");
    t_loss(64, 7, "R11 ratio change loss");

    check(long_pulses == 0, "R10 pulse one cycle wide", long_pulses, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule